// File: doc/BRIEF.md
# Command-Pointer I2C Register Slave

This block is an I2C target for buses running up to 400 kHz. It sits in front of a small internal register file of up to sixteen 8-bit entries. A fast system clock oversamples SCL and SDA, and the block drives SDA as an open-drain line through a single output-enable. The slave address is chosen by a three-level select pin. That pin reaches the block already decoded into a 2-bit code.

After a write address, the master sends bytes. A byte with its top bit set is a command. Its low nibble loads a register pointer, and nothing is stored. A byte with its top bit clear is data. It is stored at the pointer and announced on an outbound write beat. Read transactions have no register phase of their own: every byte returned is the entry named by the pointer. The pointer survives STOP and repeated START, so a read-only transaction reuses the last command.

The write beat (`wr_valid` with `wr_addr`/`wr_data`) carries no ready. I2C gives no way to hold a byte without stretching the clock, so the consumer must accept every beat in the cycle it appears. There is no back-pressure.

Top module: `i2c_cmd_reg_slave`

## Requirements
- R1: The slave answers only to 7-bit address 0x29 when `addr_sel` is 00, 0x39 when it is 01, and 0x49 when it is 10. Code 11 matches no address.
- R2: After a non-matching address, the slave leaves SDA released for the rest of the transaction (no ACK for any byte) and produces no write beat, until the next START.
- R3: A written byte with bit 7 = 1 is a command. Its bits 3:0 load the register pointer, no register changes, and no write beat appears.
- R4: A written byte with bit 7 = 0 is stored at the pointer, and `wr_valid` is high for exactly one cycle with `wr_addr` = pointer and `wr_data` = byte. The pointer does not move, so further data bytes rewrite the same entry.
- R5: The slave ACKs its own address and every written byte by holding SDA low through the ninth SCL pulse. Its SDA output changes only while SCL is low, except when START or STOP releases it.
- R6: During a read, every byte is the register at the pointer, sent MSB first, for as long as the master ACKs.
- R7: When the master NACKs a read byte, the slave releases SDA and keeps it released until the next START.
- R8: The pointer keeps its value across STOP, repeated START and transactions to other addresses.
- R9: A START or STOP in the middle of a byte abandons that byte: no register is written and SDA is released. A START begins a new address phase.
- R10: After reset, every register and the pointer are zero, SDA is released and `wr_valid` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL as seen on the pad |
| sda_i | input | 1 | SDA as seen on the pad |
| sda_oe | output | 1 | 1 pulls SDA low, 0 releases it |
| addr_sel | input | 2 | Decoded address select: 00 low, 01 float, 10 high |
| wr_valid | output | 1 | One-cycle write beat for a stored data byte |
| wr_addr | output | 4 | Register index of the write beat |
| wr_data | output | 8 | Byte of the write beat |

## Verification
A data write and a pointer-driven read of the same entry meet in the register file: the write lands on the falling edge that ends a byte, and the read load happens on the falling edge that ends a read address. The bench provokes the tightest case. It writes a data byte, issues a repeated START with no STOP between, and reads the same entry at once. It judges the result by checking that the first returned byte is the value just written, not the earlier contents. The command byte and the data byte also share the same byte-completion point. The bench checks that a command changes the pointer but produces no write beat.

// File: rtl/i2c_cr_pkg.sv
package i2c_cr_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_AACK,
    ST_WR,
    ST_WACK,
    ST_RD,
    ST_RACK
  } i2c_st_t;

  localparam logic [6:0] SA_LOW   = 7'h29;
  localparam logic [6:0] SA_FLOAT = 7'h39;
  localparam logic [6:0] SA_HIGH  = 7'h49;

  localparam int PTR_W  = 4;
  localparam int DATA_W = 8;

endpackage

// File: rtl/i2c_cr_sync.sv
module i2c_cr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic q,
  output logic rise,
  output logic fall
);

  logic [STAGES-1:0] chain;
  logic              prev;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '1;
      prev  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], din};
      prev  <= chain[STAGES-1];
    end
  end

  assign q    = chain[STAGES-1];
  assign rise = q & ~prev;
  assign fall = ~q & prev;

endmodule

// File: rtl/i2c_cr_regfile.sv
module i2c_cr_regfile #(
  parameter int NREGS = 16,
  parameter int AW    = 4,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [NREGS];

  for (genvar g = 0; g < NREGS; g++) begin : g_entry
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        mem[g] <= '0;
      else if (we && waddr == AW'(g))    mem[g] <= wdata;
    end
  end

  always_comb begin
    rdata = '0;
    for (int i = 0; i < NREGS; i++)
      if (raddr == AW'(i)) rdata = mem[i];
  end

endmodule

// File: rtl/i2c_cmd_reg_slave.sv
module i2c_cmd_reg_slave
  import i2c_cr_pkg::*;
#(
  parameter int NREGS       = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        scl_i,
  input  logic        sda_i,
  output logic        sda_oe,
  input  logic [1:0]  addr_sel,
  output logic        wr_valid,
  output logic [3:0]  wr_addr,
  output logic [7:0]  wr_data
);

  localparam int CNT_W = $clog2(DATA_W + 1);

  logic scl_s, scl_r, scl_f;
  logic sda_s, sda_r, sda_f;

  i2c_cr_sync #(.STAGES(SYNC_STAGES)) u_scl (
    .clk(clk), .rst_n(rst_n), .din(scl_i), .q(scl_s), .rise(scl_r), .fall(scl_f));
  i2c_cr_sync #(.STAGES(SYNC_STAGES)) u_sda (
    .clk(clk), .rst_n(rst_n), .din(sda_i), .q(sda_s), .rise(sda_r), .fall(sda_f));

  logic start_evt, stop_evt;
  assign start_evt = scl_s & sda_f;
  assign stop_evt  = scl_s & sda_r;

  // address decode from the three-level select code
  logic       sa_ok;
  logic [6:0] sa_val;
  always_comb begin
    sa_ok  = 1'b1;
    sa_val = SA_LOW;
    unique case (addr_sel)
      2'b00:   sa_val = SA_LOW;
      2'b01:   sa_val = SA_FLOAT;
      2'b10:   sa_val = SA_HIGH;
      default: sa_ok  = 1'b0;
    endcase
  end

  i2c_st_t           st;
  logic [CNT_W-1:0]  bit_cnt;
  logic [DATA_W-1:0] sh;
  logic [DATA_W-1:0] tx;
  logic [PTR_W-1:0]  ptr;
  logic              rnw;
  logic              m_ack;
  logic [DATA_W-1:0] rf_rdata;

  logic byte_end, data_store;
  assign byte_end   = scl_f && (bit_cnt == CNT_W'(DATA_W)) && !start_evt && !stop_evt;
  assign data_store = byte_end && (st == ST_WR) && !sh[DATA_W-1];

  i2c_cr_regfile #(.NREGS(NREGS), .AW(PTR_W), .DW(DATA_W)) u_rf (
    .clk(clk), .rst_n(rst_n), .we(data_store), .waddr(ptr), .wdata(sh),
    .raddr(ptr), .rdata(rf_rdata));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      bit_cnt  <= '0;
      sh       <= '0;
      tx       <= '0;
      ptr      <= '0;
      rnw      <= 1'b0;
      m_ack    <= 1'b0;
      sda_oe   <= 1'b0;
      wr_valid <= 1'b0;
      wr_addr  <= '0;
      wr_data  <= '0;
    end else begin
      wr_valid <= 1'b0;
      if (start_evt) begin
        st      <= ST_ADDR;
        bit_cnt <= '0;
        sda_oe  <= 1'b0;
      end else if (stop_evt) begin
        st     <= ST_IDLE;
        sda_oe <= 1'b0;
      end else begin
        unique case (st)
          ST_ADDR, ST_WR: begin
            if (scl_r) begin
              sh      <= {sh[DATA_W-2:0], sda_s};
              bit_cnt <= bit_cnt + 1'b1;
            end else if (byte_end) begin
              if (st == ST_ADDR) begin
                if (sa_ok && sh[7:1] == sa_val) begin
                  sda_oe <= 1'b1;
                  rnw    <= sh[0];
                  st     <= ST_AACK;
                end else begin
                  st <= ST_IDLE;
                end
              end else begin
                sda_oe <= 1'b1;
                st     <= ST_WACK;
                if (sh[DATA_W-1]) begin
                  ptr <= sh[PTR_W-1:0];
                end else begin
                  wr_valid <= 1'b1;
                  wr_addr  <= ptr;
                  wr_data  <= sh;
                end
              end
            end
          end
          ST_AACK: if (scl_f) begin
            bit_cnt <= '0;
            if (rnw) begin
              tx     <= rf_rdata;
              sda_oe <= ~rf_rdata[DATA_W-1];
              st     <= ST_RD;
            end else begin
              sda_oe <= 1'b0;
              st     <= ST_WR;
            end
          end
          ST_WACK: if (scl_f) begin
            sda_oe  <= 1'b0;
            bit_cnt <= '0;
            st      <= ST_WR;
          end
          ST_RD: begin
            if (scl_r) begin
              bit_cnt <= bit_cnt + 1'b1;
            end else if (scl_f) begin
              if (bit_cnt == CNT_W'(DATA_W)) begin
                sda_oe <= 1'b0;
                st     <= ST_RACK;
              end else begin
                sda_oe <= ~tx[DATA_W-2];
                tx     <= {tx[DATA_W-2:0], 1'b0};
              end
            end
          end
          ST_RACK: begin
            if (scl_r) begin
              m_ack <= ~sda_s;
            end else if (scl_f) begin
              if (m_ack) begin
                tx      <= rf_rdata;
                sda_oe  <= ~rf_rdata[DATA_W-1];
                bit_cnt <= '0;
                st      <= ST_RD;
              end else begin
                st <= ST_IDLE;
              end
            end
          end
          default: st <= ST_IDLE;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2c_cmd_reg_slave_chk.sv
module i2c_cmd_reg_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       scl_s,
  input logic       start_evt,
  input logic       stop_evt,
  input logic       sda_oe,
  input logic       wr_valid,
  input logic [7:0] wr_data,
  input logic [3:0] ptr
);

  assert_strobe_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |=> !wr_valid);

  assert_cmd_not_stored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> !wr_data[7]);

  assert_release_on_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> !sda_oe);

  assert_ptr_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    stop_evt |=> $stable(ptr));

  assert_sda_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (scl_s && $past(scl_s) && !$past(start_evt) && !$past(stop_evt)) |-> $stable(sda_oe));

endmodule

bind i2c_cmd_reg_slave i2c_cmd_reg_slave_chk u_chk (
  .clk(clk), .rst_n(rst_n), .scl_s(scl_s), .start_evt(start_evt),
  .stop_evt(stop_evt), .sda_oe(sda_oe), .wr_valid(wr_valid),
  .wr_data(wr_data), .ptr(ptr));

// File: tb/tb_i2c_cmd_reg_slave.sv
`timescale 1ns/1ps
module tb_i2c_cmd_reg_slave;

  localparam int Q = 10;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       scl_m = 1'b1;
  logic       sda_m = 1'b1;
  logic [1:0] addr_sel = 2'b00;
  logic       sda_oe;
  logic       wr_valid;
  logic [3:0] wr_addr;
  logic [7:0] wr_data;
  wire        sda_line = sda_m & ~sda_oe;

  int total = 0;
  int bad = 0;
  int beats = 0;
  int last_a = -1;
  int last_d = -1;

  always #2 clk = ~clk;

  i2c_cmd_reg_slave dut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_m), .sda_i(sda_line), .sda_oe(sda_oe),
    .addr_sel(addr_sel), .wr_valid(wr_valid), .wr_addr(wr_addr), .wr_data(wr_data));

  always @(posedge clk) if (wr_valid) begin
    beats  <= beats + 1;
    last_a <= int'(wr_addr);
    last_d <= int'(wr_data);
  end

  function automatic logic [7:0] dval(input int i);
    return 8'((i * 37 + 5) & 8'h7F);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    sda_m = b; tick(Q); scl_m = 1'b1; tick(2*Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic get_bit(output logic b);
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(2*Q); b = sda_line; scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_start();
    sda_m = 1'b1; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b0; tick(Q); scl_m = 1'b0; tick(Q);
  endtask

  task automatic bus_stop();
    sda_m = 1'b0; tick(Q); scl_m = 1'b1; tick(Q); sda_m = 1'b1; tick(2*Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic x;
    for (int k = 7; k >= 0; k--) put_bit(b[k]);
    get_bit(x);
    ack = ~x;
  endtask

  task automatic recv_byte(input logic master_ack, output logic [7:0] d);
    logic x;
    for (int k = 7; k >= 0; k--) begin get_bit(x); d[k] = x; end
    put_bit(~master_ack);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic       ack;
    logic [7:0] d;
    int         b0;
    tick(5);
    chk("R10 sda_oe in reset", int'(sda_oe), 0);
    chk("R10 wr_valid in reset", int'(wr_valid), 0);
    rst_n = 1'b1;
    tick(5);

    // R10: pointer and register 0 are zero after reset
    bus_start(); send_byte({7'h29, 1'b1}, ack);
    chk("R5 addr ack on read", int'(ack), 1);
    recv_byte(1'b0, d); bus_stop();
    chk("R10 reg0 after reset", int'(d), 0);

    // R1/R2: full address sweep for select code 00
    for (int a = 0; a < 128; a++) begin
      bus_start(); send_byte({7'(a), 1'b0}, ack); bus_stop();
      chk("R1 R2 address sweep code 00", int'(ack), (a == 'h29) ? 1 : 0);
    end
    // R1: other select codes against all three addresses
    for (int s = 1; s < 4; s++) begin
      addr_sel = 2'(s);
      for (int k = 0; k < 3; k++) begin
        bus_start(); send_byte({7'(7'h29 + 7'(k * 16)), 1'b0}, ack); bus_stop();
        chk("R1 select code", int'(ack), (s == k) ? 1 : 0);
      end
    end
    addr_sel = 2'b10;

    // R3/R4/R5: command then two data bytes per register
    for (int i = 0; i < 16; i++) begin
      bus_start(); send_byte({7'h49, 1'b0}, ack);
      chk("R5 write addr ack", int'(ack), 1);
      b0 = beats;
      send_byte(8'h80 | 8'(i), ack);
      chk("R5 command ack", int'(ack), 1);
      tick(2);
      chk("R3 command gives no beat", beats, b0);
      send_byte(dval(i) ^ 8'h7F, ack);
      chk("R5 data ack", int'(ack), 1);
      send_byte(dval(i), ack);
      bus_stop();
      chk("R4 beat count", beats - b0, 2);
      chk("R4 beat addr", last_a, i);
      chk("R4 beat data", last_d, int'(dval(i)));
    end

    // R6/R7/R8: set pointer, STOP, read-only transaction of two bytes
    for (int i = 15; i >= 0; i--) begin
      bus_start(); send_byte({7'h49, 1'b0}, ack); send_byte(8'h80 | 8'(i), ack); bus_stop();
      bus_start(); send_byte({7'h49, 1'b1}, ack);
      recv_byte(1'b1, d);
      chk("R8 R6 first read byte", int'(d), int'(dval(i)));
      recv_byte(1'b0, d);
      chk("R6 repeated read byte", int'(d), int'(dval(i)));
      tick(8);
      chk("R7 released after nack", int'(sda_oe), 0);
      bus_stop();
    end

    // R9/R8: write then repeated START read of same entry
    bus_start(); send_byte({7'h49, 1'b0}, ack); send_byte(8'h85, ack); send_byte(8'h11, ack);
    bus_start(); send_byte({7'h49, 1'b1}, ack);
    chk("R9 addr ack after repeated start", int'(ack), 1);
    recv_byte(1'b0, d); bus_stop();
    chk("R8 write then repeated start read", int'(d), 'h11);

    // R2: foreign address, bytes ignored, pointer untouched
    b0 = beats;
    bus_start(); send_byte({7'h29, 1'b0}, ack);
    chk("R2 foreign addr nack", int'(ack), 0);
    send_byte(8'h83, ack);
    chk("R2 foreign command nack", int'(ack), 0);
    send_byte(8'h22, ack);
    chk("R2 foreign data nack", int'(ack), 0);
    bus_stop();
    chk("R2 no beat for foreign", beats, b0);
    bus_start(); send_byte({7'h49, 1'b1}, ack); recv_byte(1'b0, d); bus_stop();
    chk("R2 R8 pointer kept", int'(d), 'h11);

    // R9: STOP in the middle of a data byte
    bus_start(); send_byte({7'h49, 1'b0}, ack); send_byte(8'h83, ack);
    put_bit(1'b0); put_bit(1'b1); put_bit(1'b1); put_bit(1'b1);
    bus_stop();
    chk("R9 no beat on aborted byte", beats, b0);
    bus_start(); send_byte({7'h49, 1'b1}, ack); recv_byte(1'b0, d); bus_stop();
    chk("R9 register intact after abort", int'(d), int'(dval(3)));

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule